// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block sits beside a processor core's bus and examines every bus cycle for a programmed breakpoint. It has two channels. Each channel compares the cycle address with a stored value, and a mask can exclude chosen address bits from that compare. Each channel can also require a particular address-space identifier. It also filters on the bus used, on whether the cycle is an instruction fetch or a data access, on the direction, and on the operand size. The second channel (B) can also compare the data value on the bus under its own mask.

The two channels either raise breaks on their own, or form a two-step sequence. In the sequence, channel A arms channel B, and only a later B match requests the break. The break request is combinational and appears in the same cycle as the matching bus cycle. A companion output marks the breaks caused by instruction fetches, so the core can take them before the instruction executes. Software programs the channels through a simple indexed write port. A sticky per-channel hit flag records matches until software clears it by writing zero.

Top module: `bkp_top`

## Requirements
- R1: After reset all registers are zero, `brk_req`, `brk_before`, `hit_a` and `hit_b` are low, and no bus cycle matches because every condition selector is zero.
- R2: A channel's address matches when every bit whose mask bit is 0 equals the compare address; mask bits set to 1 are ignored. Fetches always come from even addresses, so a fetch-only channel with an odd compare address and a zero mask never matches.
- R3: When condition bit 0 is 1, `bus_asid` must equal the channel's 8-bit identifier; when bit 0 is 0 the identifier is ignored.
- R4: Condition bits [2:1] select the bus (bit1 = local cycle `bus_ext`=0, bit2 = external `bus_ext`=1). Bits [4:3] select the kind (bit3 = fetch, bit4 = data). Bits [6:5] select the direction (bit5 = read, bit6 = write). A cycle matches only if its value is selected in all three fields.
- R5: An instruction fetch is always treated as a read, whatever `bus_write` says, so a channel selecting fetch and only write never matches.
- R6: Condition bits [8:7] give the size: 00 means any size, otherwise the value must equal `bus_size` (01 byte, 10 word, 11 long).
- R7: When channel B condition bit 9 is 1, `bus_data` must equal the data compare value on every bit whose data-mask bit is 0. Channel A has no data compare.
- R8: In independent mode (control bit 0 = 0), `brk_req` is high in exactly the cycle in which a valid bus cycle matches channel A or channel B.
- R9: In sequential mode (control bit 0 = 1), an A match in an earlier cycle arms the sequencer, and `brk_req` is high only for a B match while armed. Raising the break clears the armed state, and so does any control write.
- R10: `hit_a`/`hit_b` go high the cycle after a match of their channel in either mode, and stay high until a status write with bit 0 (A) or bit 1 (B) equal to 0. A write with the bit at 1 leaves the flag unchanged, and a match in the same cycle wins.
- R11: `brk_before` is high together with `brk_req` exactly when the matching cycle is an instruction fetch.
- R12: Register indices are: per channel c (A=0, B=1) address at 4c, address mask at 4c+1, identifier at 4c+2, condition at 4c+3; B data at 8, B data mask at 9, control at 10, status at 11. A write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_ext | input | 1 | 1 = external bus, 0 = local bus |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write (ignored for fetches) |
| bus_size | input | 2 | 01 byte, 10 word, 11 long |
| brk_req | output | 1 | Break request, same cycle as the match |
| brk_before | output | 1 | The break comes from a fetch and is taken before execution |
| hit_a | output | 1 | Sticky channel A match flag |
| hit_b | output | 1 | Sticky channel B match flag |

## Verification
The bench drives a fetch that has its write line asserted against a channel set for fetch plus write. A design that took the raw write line would break there. It puts fetches at even addresses next to an odd compare address, and it checks that a compare value written in a given cycle does not apply until the next one. In sequential mode it sends B before A, then A followed by B twice, then A followed by a control rewrite. A sequencer that let B fire without arming, or that stayed armed after a break or a rewrite, would raise extra breaks. Status writes with mixed bits expose a sticky flag that cleared on the wrong bit value.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
    localparam int NCH       = 2;
    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int IW        = 8;
    localparam int RIW       = 4;
    localparam int CW        = 10;
    localparam int CH_STRIDE = 4;
    localparam int OFS_ADDR  = 0;
    localparam int OFS_AMSK  = 1;
    localparam int OFS_ASID  = 2;
    localparam int OFS_COND  = 3;
    localparam logic [RIW-1:0] IDX_BDATA = RIW'(NCH*CH_STRIDE);
    localparam logic [RIW-1:0] IDX_BDMSK = RIW'(NCH*CH_STRIDE + 1);
    localparam logic [RIW-1:0] IDX_CTRL  = RIW'(NCH*CH_STRIDE + 2);
    localparam logic [RIW-1:0] IDX_STAT  = RIW'(NCH*CH_STRIDE + 3);

    typedef enum logic [1:0] {
        SZ_ANY  = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LONG = 2'b11
    } size_e;

    // condition word, LSB first: asid_chk, bus_sel, kind_sel, dir_sel, size_sel, data_chk
    typedef struct packed {
        logic       data_chk;
        logic [1:0] size_sel;
        logic [1:0] dir_sel;
        logic [1:0] kind_sel;
        logic [1:0] bus_sel;
        logic       asid_chk;
    } cond_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] amask;
        logic [IW-1:0] asid;
        cond_t         cond;
    } chan_cfg_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] dmask;
    } data_cfg_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [IW-1:0] asid;
        logic          ext;
        logic          fetch;
        logic          write;
        logic [1:0]    size;
    } bus_cyc_t;

    function automatic logic [RIW-1:0] reg_index(input int ch, input int ofs);
        return RIW'(ch*CH_STRIDE + ofs);
    endfunction

    // two-bit selector: bit0 admits case a, bit1 admits case b
    function automatic logic sel_ok(input logic [1:0] sel, input logic a, input logic b);
        return (sel[0] & a) | (sel[1] & b);
    endfunction

    function automatic logic masked_eq(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                       input logic [AW-1:0] ign);
        return ((x ^ y) & ~ign) == '0;
    endfunction
endpackage

// File: rtl/bkp_regs.sv
module bkp_regs import bkp_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RIW-1:0] idx,
    input  logic [DW-1:0]  wdata,
    output chan_cfg_t      cfg_a,
    output chan_cfg_t      cfg_b,
    output data_cfg_t      dcfg_b,
    output logic           seq_mode,
    output logic           ctrl_wr,
    output logic           stat_wr,
    output logic [1:0]     stat_keep
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q.addr  <= '0;
                q.amask <= '0;
                q.asid  <= '0;
                q.cond  <= '0;
            end else if (we) begin
                if (idx == reg_index(c, OFS_ADDR)) q.addr  <= wdata;
                if (idx == reg_index(c, OFS_AMSK)) q.amask <= wdata;
                if (idx == reg_index(c, OFS_ASID)) q.asid  <= wdata[IW-1:0];
                if (idx == reg_index(c, OFS_COND)) q.cond  <= cond_t'(wdata[CW-1:0]);
            end
        end
    end

    assign cfg_a = g_ch[0].q;
    assign cfg_b = g_ch[1].q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dcfg_b   <= '0;
            seq_mode <= 1'b0;
        end else if (we) begin
            if (idx == IDX_BDATA) dcfg_b.data  <= wdata;
            if (idx == IDX_BDMSK) dcfg_b.dmask <= wdata;
            if (idx == IDX_CTRL)  seq_mode     <= wdata[0];
        end
    end

    assign ctrl_wr   = we && (idx == IDX_CTRL);
    assign stat_wr   = we && (idx == IDX_STAT);
    assign stat_keep = wdata[1:0];

    logic unused_wd;
    assign unused_wd = ^wdata[DW-1:CW];
endmodule

// File: rtl/bkp_chan.sv
module bkp_chan import bkp_pkg::*; #(
    parameter bit HAS_DATA = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  data_cfg_t dcfg,
    input  bus_cyc_t  cyc,
    output logic      hit
);
    logic eff_write, addr_ok, asid_ok, bus_ok, kind_ok, dir_ok, size_ok, data_ok;

    // a fetch is a read no matter what the write line says
    assign eff_write = cyc.write & ~cyc.fetch;
    assign addr_ok   = masked_eq(cyc.addr, cfg.addr, cfg.amask);
    assign asid_ok   = ~cfg.cond.asid_chk | (cyc.asid == cfg.asid);
    assign bus_ok    = sel_ok(cfg.cond.bus_sel,  ~cyc.ext,   cyc.ext);
    assign kind_ok   = sel_ok(cfg.cond.kind_sel, cyc.fetch,  ~cyc.fetch);
    assign dir_ok    = sel_ok(cfg.cond.dir_sel,  ~eff_write, eff_write);
    assign size_ok   = (cfg.cond.size_sel == SZ_ANY) | (cfg.cond.size_sel == cyc.size);

    if (HAS_DATA) begin : g_data
        assign data_ok = ~cfg.cond.data_chk | masked_eq(cyc.data, dcfg.data, dcfg.dmask);
    end else begin : g_nodata
        logic unused_d;
        assign unused_d = ^{dcfg, cyc.data, cfg.cond.data_chk};
        assign data_ok  = 1'b1;
    end

    assign hit = cyc.valid & addr_ok & asid_ok & bus_ok & kind_ok & dir_ok & size_ok & data_ok;

    AST_FETCH_NEVER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cyc.valid && cyc.fetch && cfg.cond.dir_sel == 2'b10) |-> !hit); // R5
endmodule

// File: rtl/bkp_seq.sv
module bkp_seq import bkp_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       seq_mode,
    input  logic       ctrl_wr,
    input  logic       stat_wr,
    input  logic [1:0] stat_keep,
    input  logic       match_a,
    input  logic       match_b,
    input  logic       cyc_fetch,
    output logic       brk_req,
    output logic       brk_before,
    output logic       hit_a,
    output logic       hit_b
);
    logic arm_q;
    logic clr_a, clr_b;

    assign brk_req    = seq_mode ? (match_b & arm_q) : (match_a | match_b);
    assign brk_before = brk_req & cyc_fetch;

    always_ff @(posedge clk) begin
        if (rst)                      arm_q <= 1'b0;
        else if (ctrl_wr || brk_req)  arm_q <= 1'b0;
        else if (seq_mode && match_a) arm_q <= 1'b1;
    end

    assign clr_a = stat_wr & ~stat_keep[0];
    assign clr_b = stat_wr & ~stat_keep[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_a <= 1'b0;
            hit_b <= 1'b0;
        end else begin
            hit_a <= match_a | (hit_a & ~clr_a);
            hit_b <= match_b | (hit_b & ~clr_b);
        end
    end

    AST_SEQ_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (seq_mode && brk_req) |=> (!seq_mode || !brk_req)); // R9
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hit_a && !stat_wr) |=> hit_a); // R10
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit_a && !hit_b && !arm_q)); // R1
endmodule

// File: rtl/bkp_top.sv
module bkp_top import bkp_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [RIW-1:0] cfg_idx,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           bus_valid,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_data,
    input  logic [IW-1:0]  bus_asid,
    input  logic           bus_ext,
    input  logic           bus_fetch,
    input  logic           bus_write,
    input  logic [1:0]     bus_size,
    output logic           brk_req,
    output logic           brk_before,
    output logic           hit_a,
    output logic           hit_b
);
    chan_cfg_t  cfg_a, cfg_b;
    data_cfg_t  dcfg_b;
    bus_cyc_t   cyc;
    logic       seq_mode, ctrl_wr, stat_wr;
    logic [1:0] stat_keep;
    logic       match_a, match_b;

    assign cyc = '{valid: bus_valid, addr: bus_addr, data: bus_data, asid: bus_asid,
                   ext: bus_ext, fetch: bus_fetch, write: bus_write, size: bus_size};

    bkp_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .dcfg_b(dcfg_b), .seq_mode(seq_mode),
        .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .stat_keep(stat_keep)
    );

    bkp_chan #(.HAS_DATA(1'b0)) u_chan_a (
        .clk(clk), .rst(rst), .cfg(cfg_a), .dcfg('0), .cyc(cyc), .hit(match_a)
    );

    bkp_chan #(.HAS_DATA(1'b1)) u_chan_b (
        .clk(clk), .rst(rst), .cfg(cfg_b), .dcfg(dcfg_b), .cyc(cyc), .hit(match_b)
    );

    bkp_seq u_seq (
        .clk(clk), .rst(rst), .seq_mode(seq_mode), .ctrl_wr(ctrl_wr),
        .stat_wr(stat_wr), .stat_keep(stat_keep), .match_a(match_a), .match_b(match_b),
        .cyc_fetch(bus_fetch), .brk_req(brk_req), .brk_before(brk_before),
        .hit_a(hit_a), .hit_b(hit_b)
    );

    AST_BRK_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> bus_valid); // R8
endmodule

// File: tb/sim_bkp_top.sv
module sim_bkp_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        b_valid = 1'b0;
    logic [31:0] b_addr = '0, b_data = '0;
    logic [7:0]  b_asid = '0;
    logic        b_ext = 1'b0, b_fetch = 1'b0, b_write = 1'b0;
    logic [1:0]  b_size = 2'b10;
    logic        brk_req, brk_before, hit_a, hit_b;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] mr [0:11];
    bit m_arm = 0, m_ha = 0, m_hb = 0;

    always #(CLK_P/2) clk = ~clk;

    bkp_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .bus_valid(b_valid), .bus_addr(b_addr), .bus_data(b_data), .bus_asid(b_asid),
        .bus_ext(b_ext), .bus_fetch(b_fetch), .bus_write(b_write), .bus_size(b_size),
        .brk_req(brk_req), .brk_before(brk_before), .hit_a(hit_a), .hit_b(hit_b)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit pick(input logic [1:0] s, input bit a, input bit b);
        return (s[0] && a) || (s[1] && b);
    endfunction

    function automatic bit model_hit(input int ch);
        logic [31:0] ca = mr[ch*4], cm = mr[ch*4+1];
        logic [9:0]  cd = mr[ch*4+3][9:0];
        bit wr = b_write && !b_fetch;
        bit ok = b_valid;
        for (int i = 0; i < 32; i++)
            if (!cm[i] && ca[i] != b_addr[i]) ok = 0;
        if (cd[0] && b_asid != mr[ch*4+2][7:0]) ok = 0;
        if (!pick(cd[2:1], !b_ext, b_ext)) ok = 0;
        if (!pick(cd[4:3], b_fetch, !b_fetch)) ok = 0;
        if (!pick(cd[6:5], !wr, wr)) ok = 0;
        if (cd[8:7] != 2'b00 && cd[8:7] != b_size) ok = 0;
        if (ch == 1 && cd[9])
            for (int i = 0; i < 32; i++)
                if (!mr[9][i] && mr[8][i] != b_data[i]) ok = 0;
        return ok;
    endfunction

    // one clock: inputs already driven; compare, advance model, cross the edge
    task automatic step(input string tag, input int want);
        bit ea, eb, seq, ebrk, clra, clrb;
        #1;
        ea = model_hit(0);
        eb = model_hit(1);
        seq = mr[10][0];
        ebrk = seq ? (eb && m_arm) : (ea || eb);
        chk(tag, "brk_req", {31'b0, brk_req}, {31'b0, ebrk});
        chk(tag, "brk_before", {31'b0, brk_before}, {31'b0, ebrk && b_fetch});
        chk(tag, "hit_a", {31'b0, hit_a}, {31'b0, m_ha});
        chk(tag, "hit_b", {31'b0, hit_b}, {31'b0, m_hb});
        if (want >= 0) chk(tag, "directed brk", {31'b0, brk_req}, want);
        clra = cfg_we && cfg_idx == 4'd11 && !cfg_wdata[0];
        clrb = cfg_we && cfg_idx == 4'd11 && !cfg_wdata[1];
        if ((cfg_we && cfg_idx == 4'd10) || ebrk) m_arm = 0;
        else if (seq && ea) m_arm = 1;
        m_ha = ea || (m_ha && !clra);
        m_hb = eb || (m_hb && !clrb);
        if (cfg_we && cfg_idx < 4'd12) mr[cfg_idx] = cfg_wdata;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        b_valid = 0; cfg_we = 1; cfg_idx = idx; cfg_wdata = val;
        step("R12", -1);
        cfg_we = 0;
    endtask

    task automatic cyc(input string tag, input logic [31:0] a, input bit f, input bit w,
                       input logic [1:0] sz, input bit ext, input logic [7:0] asid,
                       input logic [31:0] d, input int want);
        b_valid = 1; b_addr = a; b_fetch = f; b_write = w; b_size = sz;
        b_ext = ext; b_asid = asid; b_data = d;
        step(tag, want);
        b_valid = 0;
    endtask

    function automatic logic [31:0] cnd(input bit ac, input logic [1:0] bs,
        input logic [1:0] kd, input logic [1:0] dr, input logic [1:0] sz, input bit dc);
        return {22'b0, dc, sz, dr, kd, bs, ac};
    endfunction

    initial begin
        #(CLK_P*200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) mr[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: quiet after reset, zero conditions never match
        step("R1", 0);
        cyc("R1", 32'h0, 1, 0, 2'b10, 0, 8'h0, 0, 0);

        // R12: condition written in the same cycle as a matching fetch applies next cycle
        wr(4'd0, 32'h100);
        cfg_we = 1; cfg_idx = 4'd3; cfg_wdata = cnd(0, 2'b11, 2'b01, 2'b01, 2'b00, 0);
        b_valid = 1; b_addr = 32'h100; b_fetch = 1; b_write = 0;
        step("R12", 0);
        cfg_we = 0;
        cyc("R12", 32'h100, 1, 0, 2'b10, 0, 0, 0, 1);
        // R8/R11: fetch break is flagged as before-execution; data read excluded (R4)
        cyc("R11", 32'h100, 1, 0, 2'b11, 0, 0, 0, 1);
        cyc("R4", 32'h100, 0, 0, 2'b10, 0, 0, 0, 0);
        // R2: masked compare
        wr(4'd1, 32'h0000_000F);
        cyc("R2", 32'h10A, 1, 0, 2'b10, 0, 0, 0, 1);
        cyc("R2", 32'h110, 1, 0, 2'b10, 0, 0, 0, 0);
        wr(4'd1, 32'h0);
        // R5: fetch with write line set is still a read
        wr(4'd3, cnd(0, 2'b11, 2'b01, 2'b10, 2'b00, 0));
        cyc("R5", 32'h100, 1, 1, 2'b10, 0, 0, 0, 0);
        cyc("R5", 32'h100, 0, 1, 2'b10, 0, 0, 0, 0);
        wr(4'd3, cnd(0, 2'b11, 2'b11, 2'b10, 2'b00, 0));
        cyc("R4", 32'h100, 0, 1, 2'b10, 0, 0, 0, 1);
        cyc("R5", 32'h100, 1, 1, 2'b10, 0, 0, 0, 0);
        // R3: identifier check
        wr(4'd2, 32'h80);
        wr(4'd3, cnd(1, 2'b11, 2'b11, 2'b11, 2'b00, 0));
        cyc("R3", 32'h100, 0, 0, 2'b10, 0, 8'h80, 0, 1);
        cyc("R3", 32'h100, 0, 0, 2'b10, 0, 8'h81, 0, 0);
        wr(4'd3, cnd(0, 2'b11, 2'b11, 2'b11, 2'b00, 0));
        cyc("R3", 32'h100, 0, 0, 2'b10, 0, 8'h81, 0, 1);
        // R6: size
        wr(4'd3, cnd(0, 2'b11, 2'b11, 2'b11, 2'b10, 0));
        cyc("R6", 32'h100, 0, 0, 2'b10, 0, 0, 0, 1);
        cyc("R6", 32'h100, 0, 0, 2'b11, 0, 0, 0, 0);
        // R4: bus selection
        wr(4'd3, cnd(0, 2'b10, 2'b11, 2'b11, 2'b00, 0));
        cyc("R4", 32'h100, 0, 0, 2'b10, 0, 0, 0, 0);
        cyc("R4", 32'h100, 0, 0, 2'b10, 1, 0, 0, 1);
        wr(4'd3, 32'h0);
        // R7: channel B masked data compare
        wr(4'd4, 32'h2000);
        wr(4'd8, 32'hCAFE_0000);
        wr(4'd9, 32'h0000_FFFF);
        wr(4'd7, cnd(0, 2'b11, 2'b10, 2'b11, 2'b00, 1));
        cyc("R7", 32'h2000, 0, 1, 2'b11, 0, 0, 32'hCAFE_1234, 1);
        cyc("R7", 32'h2000, 0, 1, 2'b11, 0, 0, 32'hCAFF_0000, 0);
        wr(4'd7, cnd(0, 2'b11, 2'b10, 2'b11, 2'b00, 0));
        cyc("R7", 32'h2000, 0, 1, 2'b11, 0, 0, 32'hCAFF_0000, 1);
        // R10: status write clears only bits written as 0
        wr(4'd11, 32'h1);
        chk("R10", "hit_b after clear", {31'b0, hit_b}, 0);
        chk("R10", "hit_a kept", {31'b0, hit_a}, 1);
        wr(4'd11, 32'h2);
        chk("R10", "hit_a after clear", {31'b0, hit_a}, 0);
        // R2: odd fetch compare vs even fetch addresses
        wr(4'd4, 32'h31415);
        wr(4'd7, cnd(0, 2'b11, 2'b01, 2'b01, 2'b00, 0));
        cyc("R2", 32'h31414, 1, 0, 2'b10, 0, 0, 0, 0);
        cyc("R2", 32'h31416, 1, 0, 2'b10, 0, 0, 0, 0);
        // R9: sequential mode
        wr(4'd0, 32'h3000);
        wr(4'd3, cnd(0, 2'b11, 2'b10, 2'b10, 2'b00, 0));
        wr(4'd4, 32'h3010);
        wr(4'd10, 32'h1);
        cyc("R9", 32'h3010, 1, 0, 2'b10, 0, 0, 0, 0);
        cyc("R9", 32'h3000, 0, 1, 2'b10, 0, 0, 0, 0);
        cyc("R9", 32'h3010, 1, 0, 2'b10, 0, 0, 0, 1);
        cyc("R9", 32'h3010, 1, 0, 2'b10, 0, 0, 0, 0);
        cyc("R9", 32'h3000, 0, 1, 2'b10, 0, 0, 0, 0);
        wr(4'd10, 32'h1);
        cyc("R9", 32'h3010, 1, 0, 2'b10, 0, 0, 0, 0);
        // R9/R5: A set to fetch+write can never arm B
        wr(4'd3, cnd(0, 2'b11, 2'b01, 2'b10, 2'b10, 0));
        wr(4'd0, 32'h3010);
        cyc("R9", 32'h3010, 1, 1, 2'b10, 0, 0, 0, 0);
        cyc("R9", 32'h3010, 1, 0, 2'b10, 0, 0, 0, 0);
        // R8: mixed traffic against the model
        wr(4'd10, 32'h0);
        wr(4'd0, 32'h4000); wr(4'd1, 32'hF);
        wr(4'd3, cnd(0, 2'b11, 2'b10, 2'b11, 2'b00, 0));
        wr(4'd4, 32'h4008); wr(4'd5, 32'h3); wr(4'd6, 32'h11);
        wr(4'd7, cnd(1, 2'b11, 2'b01, 2'b01, 2'b00, 0));
        for (int k = 0; k < 400; k++) begin
            if (k % 25 == 24) begin
                if ($urandom % 2 == 0) wr(4'd10, $urandom % 2);
                else wr(4'd11, $urandom % 4);
            end else begin
                cyc("R8", 32'h4000 | ($urandom & 32'h1F), 1'($urandom), 1'($urandom),
                    2'($urandom), 1'($urandom),
                    ($urandom % 2 == 0) ? 8'h11 : 8'($urandom), $urandom, -1);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule